// File: doc/BRIEF.md
# Column Single-Slope Converter Digital Back End

This block is the digital half of a row of column single-slope analog-to-digital converters. A single counter runs in step with an external analog ramp. Its value goes to every column as a Gray-coded word on a shared bus. Each column watches its own comparator. On the first rising transition of that comparator within a conversion, the column latches the bus word into a capture register.

When the counter reaches its terminal count, a copy strobe moves every capture register into a hold register. The next conversion can then run while the held values are read. The hold value is decoded from Gray to binary and presented as one packed word for a downstream multiplexer. A column whose comparator never rises reports the full-scale code.

A resolution input selects 9-bit or 10-bit conversions and is sampled only at the start of a conversion. The comparator inputs are asynchronous, so each one passes through a two-stage synchroniser followed by an edge detector. A rising edge at the synchroniser output is therefore seen at a fixed offset from the counter value.

Top module: `ssadc_backend`

## Requirements
- R1: After reset, `busy` and `dataValid` are 0 and every field of `colData` is 0.
- R2: A high `convStart` sampled while idle begins a conversion, and `busy` is 1 from the following cycle.
- R3: The counter is 0 in the cycle after the start edge and increments once per cycle. If a comparator first rises in the cycle after start edge k, its column reports the binary value k+2, provided k+2 does not exceed the full-scale code.
- R4: Only the first rising comparator transition in a conversion is captured; later falls and rises in the same conversion do not change the reported value.
- R5: A column with no captured rising transition reports full scale: 511 in 9-bit mode, 1023 in 10-bit mode.
- R6: With `res10`=0 the full-scale code is 511, and `busy` falls exactly 513 cycles after the start edge. With `res10`=1 the full-scale code is 1023, and `busy` falls after 1025 cycles. In 9-bit mode no column value exceeds 511.
- R7: `dataValid` pulses for exactly one cycle, in the cycle in which `busy` first reads 0. `colData` changes only in that cycle and holds the previous results throughout the next conversion.
- R8: `convStart` is ignored while a conversion is in progress; the conversion length is unchanged.
- R9: Capture registers are cleared at every start. A comparator that was already high at the start, and never rises again, reports full scale. So does a column that captured in the previous conversion but not in this one.
- R10: `res10` is sampled only at the start edge; changing it during a conversion has no effect on length or full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| convStart | input | 1 | Request to begin a conversion |
| res10 | input | 1 | 1 selects 10-bit conversions, 0 selects 9-bit |
| cmpIn | input | NUM_COLS | Asynchronous comparator outputs, one per column |
| colData | output | NUM_COLS*CODE_BITS | Binary results; column i occupies bits [i*CODE_BITS +: CODE_BITS] |
| busy | output | 1 | High while a conversion or the copy step is in progress |
| dataValid | output | 1 | One-cycle pulse when new results appear on colData |

## Verification
The hardest situation to reach from the ports is one where a conversion's captured value differs from what a stale or re-triggered register would give. Examples are a comparator toggling several times in one conversion, a comparator held high across the start edge, and a column that captured last time but stays silent now.

The bench reaches these cases by scheduling each column's rise, fall and re-rise on exact cycle indices counted from the start edge. It also preloads comparator levels before starting, and chains conversions so that each one's expected values differ from the previous one's. During conversions it disturbs the start and resolution inputs mid-run, and it checks the held outputs while the next ramp is running.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;
  // Strobes from the sequencer to the column datapath
  typedef struct packed {
    logic clearA;  // wipe capture registers (start of conversion)
    logic run;     // counter is ramping; captures permitted
    logic copy;    // transfer capture registers to hold registers
  } ssadcStrobe_t;
endpackage

// File: rtl/ssadc_ctrl.sv
module ssadc_ctrl
  import ssadc_pkg::*;
#(
  parameter int CODE_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 convStart,
  input  logic                 res10,
  output ssadcStrobe_t         strb,
  output logic [CODE_BITS-1:0] grayBus,
  output logic [CODE_BITS-1:0] fullGray,
  output logic                 busy,
  output logic                 dataValid
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_COPY} ctrlState_t;

  localparam logic [CODE_BITS-1:0] TERM_HI = {CODE_BITS{1'b1}};
  localparam logic [CODE_BITS-1:0] TERM_LO = {1'b0, {(CODE_BITS-1){1'b1}}};

  ctrlState_t           state;
  logic                 resQ;
  logic [CODE_BITS-1:0] cnt;
  logic [CODE_BITS-1:0] termCode;

  assign termCode = resQ ? TERM_HI : TERM_LO;
  assign grayBus  = cnt ^ (cnt >> 1);
  assign fullGray = termCode ^ (termCode >> 1);

  always_comb begin
    strb.clearA = (state == S_IDLE) && convStart;
    strb.run    = (state == S_RUN);
    strb.copy   = (state == S_COPY);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      resQ      <= 1'b0;
      cnt       <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= (state == S_COPY);
      unique case (state)
        S_IDLE: if (convStart) begin
          state <= S_RUN;
          cnt   <= '0;
          resQ  <= res10;
        end
        S_RUN: begin
          if (cnt == termCode) state <= S_COPY;
          else                 cnt   <= cnt + 1'b1;
        end
        S_COPY:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ssadc_datapath.sv
module ssadc_datapath
  import ssadc_pkg::*;
#(
  parameter int NUM_COLS  = 4,
  parameter int CODE_BITS = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  ssadcStrobe_t                  strb,
  input  logic [CODE_BITS-1:0]          grayBus,
  input  logic [CODE_BITS-1:0]          fullGray,
  input  logic [NUM_COLS-1:0]           cmpIn,
  output logic [NUM_COLS*CODE_BITS-1:0] colData
);
  function automatic logic [CODE_BITS-1:0] grayToBin(input logic [CODE_BITS-1:0] g);
    logic [CODE_BITS-1:0] b;
    b[CODE_BITS-1] = g[CODE_BITS-1];
    for (int i = CODE_BITS - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic                 syncA, syncB, prevB, captured;
    logic [CODE_BITS-1:0] regA, regB;
    logic                 riseSeen;

    assign riseSeen = syncB & ~prevB;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        syncA    <= 1'b0;
        syncB    <= 1'b0;
        prevB    <= 1'b0;
        captured <= 1'b0;
        regA     <= '0;
        regB     <= '0;
      end else begin
        syncA <= cmpIn[c];
        syncB <= syncA;
        prevB <= syncB;
        if (strb.clearA) begin
          regA     <= '0;
          captured <= 1'b0;
        end else if (strb.run && riseSeen && !captured) begin
          regA     <= grayBus;
          captured <= 1'b1;
        end
        if (strb.copy) regB <= captured ? regA : fullGray;
      end
    end

    assign colData[c*CODE_BITS +: CODE_BITS] = grayToBin(regB);
  end
endmodule

// File: rtl/ssadc_backend.sv
module ssadc_backend
  import ssadc_pkg::*;
#(
  parameter int NUM_COLS  = 4,
  parameter int CODE_BITS = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          convStart,
  input  logic                          res10,
  input  logic [NUM_COLS-1:0]           cmpIn,
  output logic [NUM_COLS*CODE_BITS-1:0] colData,
  output logic                          busy,
  output logic                          dataValid
);
  ssadcStrobe_t         strb;
  logic [CODE_BITS-1:0] grayBus;
  logic [CODE_BITS-1:0] fullGray;

  ssadc_ctrl #(.CODE_BITS(CODE_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .convStart(convStart), .res10(res10),
    .strb(strb), .grayBus(grayBus), .fullGray(fullGray),
    .busy(busy), .dataValid(dataValid)
  );

  ssadc_datapath #(.NUM_COLS(NUM_COLS), .CODE_BITS(CODE_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .grayBus(grayBus),
    .fullGray(fullGray), .cmpIn(cmpIn), .colData(colData)
  );
endmodule

// File: rtl/ssadc_backend_chk.sv
module ssadc_backend_chk #(
  parameter int NUM_COLS  = 4,
  parameter int CODE_BITS = 10
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          convStart,
  input logic                          res10,
  input logic [NUM_COLS*CODE_BITS-1:0] colData,
  input logic                          busy,
  input logic                          dataValid
);
  logic resSeen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resSeen <= 1'b0;
    else if (!busy && convStart) resSeen <= res10;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && convStart) |=> busy); // R2
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |=> !dataValid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    dataValid |-> !busy); // R7
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> dataValid); // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dataValid |-> $stable(colData)); // R7

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_rng
    AST_RANGE_9BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (dataValid && !resSeen) |-> (colData[c*CODE_BITS + CODE_BITS-1] == 1'b0)); // R6
  end
endmodule

bind ssadc_backend ssadc_backend_chk #(.NUM_COLS(NUM_COLS), .CODE_BITS(CODE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .convStart(convStart), .res10(res10),
  .colData(colData), .busy(busy), .dataValid(dataValid)
);

// File: tb/ssadc_backend_bench.sv
module ssadc_backend_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int CB = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic convStart = 1'b0;
  logic res10 = 1'b0;
  logic [NC-1:0] cmpIn = '0;
  logic [NC*CB-1:0] colData;
  logic busy, dataValid;

  int checks = 0;
  int errors = 0;
  int raiseAt [NC];
  int prevExp [NC];
  bit doneFlag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssadc_backend #(.NUM_COLS(NC), .CODE_BITS(CB)) u_ssadc_backend (
    .clk(clk), .rst_n(rst_n), .convStart(convStart), .res10(res10),
    .cmpIn(cmpIn), .colData(colData), .busy(busy), .dataValid(dataValid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int colVal(input int c);
    return int'(colData[c*CB +: CB]);
  endfunction

  // One conversion; raiseAt[c] < 0 means the comparator never rises
  task automatic runConv(input bit res, input bit disturb, input bit toggles,
                         input logic [NC-1:0] holdHigh, input string tag);
    int term = res ? 1023 : 511;
    int k = 0;
    int expv [NC];
    @(negedge clk);
    cmpIn = holdHigh;
    repeat (4) @(negedge clk);
    res10 = res;
    convStart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    convStart = 1'b0;
    forever begin
      if (k > 0 && !busy) break;
      for (int c = 0; c < NC; c++) begin
        if (raiseAt[c] == k) cmpIn[c] = 1'b1;
        if (toggles && raiseAt[c] >= 0 && k == raiseAt[c] + 6)  cmpIn[c] = 1'b0;
        if (toggles && raiseAt[c] >= 0 && k == raiseAt[c] + 12) cmpIn[c] = 1'b1;
      end
      if (disturb && k == 50) res10 = ~res;
      if (disturb && k == 60) convStart = 1'b1;
      if (disturb && k == 61) convStart = 1'b0;
      if (k == 100) begin
        check("R2 busy during run", int'(busy), 1);
        for (int c = 0; c < NC; c++) check("R7 hold during next run", colVal(c), prevExp[c]);
      end
      @(posedge clk);
      @(negedge clk);
      k++;
    end
    check(disturb ? "R6/R8/R10 length" : "R6 length", k, term + 2);
    check("R7 valid pulse", int'(dataValid), 1);
    for (int c = 0; c < NC; c++) begin
      if (holdHigh[c] || raiseAt[c] < 0 || raiseAt[c] + 2 > term) expv[c] = term;
      else expv[c] = raiseAt[c] + 2;
      check(tag, colVal(c), expv[c]);
      prevExp[c] = expv[c];
    end
    @(negedge clk);
    check("R7 valid drops", int'(dataValid), 0);
    cmpIn = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 valid", int'(dataValid), 0);
    check("R1 data", int'(colData == '0), 1);
    rst_n = 1'b1;
    for (int c = 0; c < NC; c++) prevExp[c] = 0;

    // R3 basic codes, top boundary reached exactly at the terminal count
    raiseAt = '{0, 10, 300, 509};
    runConv(1'b0, 1'b0, 1'b0, '0, "R3 capture 9-bit");
    // R4 repeated toggles after first rise
    raiseAt = '{5, 40, 200, -1};
    runConv(1'b0, 1'b0, 1'b1, '0, "R4/R5 first edge only");
    // R10/R8 disturbed 10-bit run, R5 silent column
    raiseAt = '{700, 3, -1, 1021};
    runConv(1'b1, 1'b1, 1'b0, '0, "R3/R5/R10 10-bit");
    // R9 high across start and stale capture from before
    raiseAt = '{-1, -1, 20, 1000};
    runConv(1'b0, 1'b0, 1'b0, 4'b0001, "R9 cleared at start");
    // sweep of rise times in 9-bit mode, some beyond full scale
    for (int n = 0; n < 8; n++) begin
      for (int c = 0; c < NC; c++) raiseAt[c] = (n * 67 + c * 131) % 530;
      runConv(1'b0, 1'b0, 1'b0, '0, "R3/R5 sweep");
    end
    doneFlag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule